// File: doc/BRIEF.md
# TDM Input Sampling-Phase Adjuster

The block is the receive front end for eight serial time-division multiplex lanes. All lanes share one bit-cell grid and one frame-sync pulse. The block runs on a system clock at four times the bit rate, so each bit cell is four clock cycles long. Every lane has its own sampling instant. By default a lane samples three quarters of the way through each cell. A per-lane code moves that instant, and with it the frame alignment, later or earlier in half-bit steps of up to two bit-times.

A lane can also take its data from the matching transmit lane instead of its receive pin, which gives a loopback path. A global timing enable, when low, turns every requested delay into the matching advance. Each lane delivers the recovered bit with a one-cycle valid strobe. A first-bit flag marks the bit that opens the lane's shifted frame. Configuration is read from two 16-bit words. It is latched only at frame sync, so a change takes effect at a frame boundary.

Top module: `tdm_phase_align`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, bitOut, bitValid and frameStart are all zero. The latched lane configuration is all zero.
- R2: The frame-sync cycle is tick 0. With step code 00 a lane samples its input on ticks 3, 7, 11 and so on. The result shows on bitOut one cycle later, with bitValid high for that single cycle. The direction bit has no effect.
- R3: Each lane is set by a 4-bit nibble with bit 3 = loopback, bit 2 = delay direction, and bits 1:0 = step code. cfgLo[4i+3:4i] serves lane i for lanes 0 to 3. cfgHi[4(i-4)+3:4(i-4)] serves lane i for lanes 4 to 7.
- R4: With the effective direction at 1, step codes 01, 10 and 11 move the sampling instant 2, 4 and 8 cycles later.
- R5: With the direction at 0, step codes 01, 10 and 11 move the sampling instant 2, 4 and 8 cycles earlier.
- R6: A lane's tick is the frame tick minus its offset, taken modulo 4×FRAME_BITS. frameStart is high together with bitValid for the sample taken at lane tick 3, and low at all other times.
- R7: With the loopback bit set, the lane samples txLane[i] instead of rxLane[i].
- R8: With timingEn low at the frame-sync cycle, every lane's direction bit is treated as 0 for that frame.
- R9: cfgLo, cfgHi and timingEn are captured only in a frame-sync cycle. Changes at any other time have no effect until the next sync.
- R10: No bitValid is produced before the first frame sync. bitOut holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four cycles per bit cell |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | One-cycle pulse in tick 0 of each frame |
| timingEn | input | 1 | Global enable for delay direction |
| cfgLo | input | 16 | Lane 0 to 3 control nibbles |
| cfgHi | input | 16 | Lane 4 to 7 control nibbles |
| rxLane | input | 8 | Receive serial data, one bit per lane |
| txLane | input | 8 | Transmit serial data used for loopback |
| bitOut | output | 8 | Recovered bit per lane |
| bitValid | output | 8 | One-cycle strobe per recovered bit |
| frameStart | output | 8 | Marks the first bit of the lane's shifted frame |

## Verification
The assertions assume that frameSync, once seen, repeats exactly every 4×FRAME_BITS cycles. Under that assumption the free-running tick reads 0 in every sync cycle, and a lane never samples in the cycle where its offset is swapped. The stimulus asserts the first sync a few cycles after reset and then pulses it strictly periodically. Data, configuration words and the timing enable change freely, both mid-frame and just before a sync. The reference model applies configuration only at the sync cycles.

// File: rtl/tdm_phase_pkg.sv
package tdm_phase_pkg;
  localparam int LANES   = 8;
  localparam int NIB_W   = 4;
  localparam int CFG_W   = 16;
  localparam int PHASES  = 4;
  localparam int OFF_W   = 5;
  localparam int LANES_PER_WORD = CFG_W / NIB_W;

  typedef struct packed {
    logic       loop;
    logic       dlyDir;
    logic [1:0] step;
  } laneCfg_t;

  typedef struct packed {
    logic [LANES-1:0] sample;
    logic [LANES-1:0] first;
    logic [LANES-1:0] loopSel;
  } laneStrobe_t;

  // signed shift in clock cycles: + later, - earlier
  function automatic logic signed [OFF_W-1:0] stepOffset(laneCfg_t c, logic en);
    logic signed [OFF_W-1:0] mag;
    case (c.step)
      2'd1:    mag = OFF_W'(2);
      2'd2:    mag = OFF_W'(4);
      2'd3:    mag = OFF_W'(8);
      default: mag = '0;
    endcase
    return (c.dlyDir & en) ? mag : -mag;
  endfunction
endpackage

// File: rtl/tdm_phase_ctrl.sv
module tdm_phase_ctrl
  import tdm_phase_pkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic             timingEn,
  input  logic [CFG_W-1:0] cfgLo,
  input  logic [CFG_W-1:0] cfgHi,
  output laneStrobe_t      strb
);
  localparam int TOTAL = FRAME_BITS * PHASES;
  localparam int TW    = $clog2(TOTAL);
  localparam int SW    = TW + 2;
  localparam logic [TW-1:0] LAST = TW'(TOTAL - 1);
  localparam logic signed [SW-1:0] TOT_S = SW'(TOTAL);

  logic [TW-1:0] tick;
  logic          synced;
  logic [2*CFG_W-1:0] cfgAll;
  logic signed [OFF_W-1:0] offNext [LANES];
  logic signed [OFF_W-1:0] offReg  [LANES];
  logic [LANES-1:0] loopNext;
  logic [LANES-1:0] loopReg;

  assign cfgAll = {cfgHi, cfgLo};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    laneCfg_t laneC;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] wrapped;
    logic [TW-1:0] laneTick;

    assign laneC       = laneCfg_t'(cfgAll[i*NIB_W +: NIB_W]);
    assign offNext[i]  = stepOffset(laneC, timingEn);
    assign loopNext[i] = laneC.loop;

    always_comb begin
      diff = $signed({2'b00, tick}) - SW'(offReg[i]);
      if (diff < 0)            wrapped = diff + TOT_S;
      else if (diff >= TOT_S)  wrapped = diff - TOT_S;
      else                     wrapped = diff;
      laneTick = wrapped[TW-1:0];
    end

    assign strb.sample[i]  = synced & (laneTick[1:0] == 2'd3);
    assign strb.first[i]   = (laneTick < TW'(PHASES));
    assign strb.loopSel[i] = loopReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick    <= '0;
      synced  <= 1'b0;
      loopReg <= '0;
      for (int i = 0; i < LANES; i++) offReg[i] <= '0;
    end else if (frameSync) begin
      tick    <= TW'(1);
      synced  <= 1'b1;
      loopReg <= loopNext;
      for (int i = 0; i < LANES; i++) offReg[i] <= offNext[i];
    end else begin
      tick <= (tick == LAST) ? '0 : tick + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_phase_dp.sv
module tdm_phase_dp
  import tdm_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] rxLane,
  input  logic [LANES-1:0] txLane,
  input  laneStrobe_t      strb,
  output logic [LANES-1:0] bitOut,
  output logic [LANES-1:0] bitValid,
  output logic [LANES-1:0] frameStart
);
  logic [LANES-1:0] laneIn;

  for (genvar i = 0; i < LANES; i++) begin : g_mux
    assign laneIn[i] = strb.loopSel[i] ? txLane[i] : rxLane[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitOut     <= '0;
      bitValid   <= '0;
      frameStart <= '0;
    end else begin
      bitValid   <= strb.sample;
      frameStart <= strb.sample & strb.first;
      bitOut     <= (bitOut & ~strb.sample) | (laneIn & strb.sample);
    end
  end
endmodule

// File: rtl/tdm_phase_align.sv
module tdm_phase_align
  import tdm_phase_pkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic             timingEn,
  input  logic [CFG_W-1:0] cfgLo,
  input  logic [CFG_W-1:0] cfgHi,
  input  logic [LANES-1:0] rxLane,
  input  logic [LANES-1:0] txLane,
  output logic [LANES-1:0] bitOut,
  output logic [LANES-1:0] bitValid,
  output logic [LANES-1:0] frameStart
);
  laneStrobe_t strb;

  tdm_phase_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .timingEn(timingEn),
    .cfgLo(cfgLo), .cfgHi(cfgHi), .strb(strb)
  );

  tdm_phase_dp dp_i (
    .clk(clk), .rstN(rstN), .rxLane(rxLane), .txLane(txLane), .strb(strb),
    .bitOut(bitOut), .bitValid(bitValid), .frameStart(frameStart)
  );
endmodule

// File: rtl/tdm_phase_align_chk.sv
module tdm_phase_align_chk
  import tdm_phase_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic [LANES-1:0] bitOut,
  input logic [LANES-1:0] bitValid,
  input logic [LANES-1:0] frameStart
);
  logic seenSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          seenSync <= 1'b0;
    else if (frameSync) seenSync <= 1'b1;
  end

  a_r10_quiet_before_sync: assert property (@(posedge clk) disable iff (!rstN)
    !seenSync |-> (bitValid == '0));

  a_r10_hold_between_strobes: assert property (@(posedge clk) disable iff (!rstN)
    ((bitOut ^ $past(bitOut)) & ~bitValid) == '0);

  a_r2_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid & $past(bitValid)) == '0);

  a_r6_flag_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart & ~bitValid) == '0);
endmodule

bind tdm_phase_align tdm_phase_align_chk chk_i (
  .clk(clk), .rstN(rstN), .frameSync(frameSync),
  .bitOut(bitOut), .bitValid(bitValid), .frameStart(frameStart)
);

// File: tb/tdm_phase_align_tb_top.sv
module tdm_phase_align_tb_top;
  localparam int FRAME_BITS = 32;
  localparam int TOT  = FRAME_BITS * 4;
  localparam int T0   = 7;
  localparam int NFR  = 36;
  localparam int NCYC = T0 + NFR * TOT + 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, frameSync, timingEn;
  logic [15:0] cfgLo, cfgHi;
  logic [7:0] rxLane, txLane, bitOut, bitValid, frameStart;

  tdm_phase_align #(.FRAME_BITS(FRAME_BITS)) dut_i (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .timingEn(timingEn),
    .cfgLo(cfgLo), .cfgHi(cfgHi), .rxLane(rxLane), .txLane(txLane),
    .bitOut(bitOut), .bitValid(bitValid), .frameStart(frameStart)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] expValid, expFirst, expOut;
  logic [31:0] appliedCfg;
  bit appliedEn;
  bit syncSeen;
  int lastSync;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // R3: nibble {loop, dir, step[1:0]}, lane i at bits 4i+3:4i of {cfgHi,cfgLo}
  function automatic int offB(logic [3:0] nib, bit en);
    int mag;
    mag = (nib[1:0] == 2'd0) ? 0 : (1 << nib[1:0]);
    return (nib[2] && en) ? mag : -mag;
  endfunction

  function automatic string tagFor(int lane);
    logic [3:0] nib;
    nib = appliedCfg[lane*4 +: 4];
    if (!syncSeen) return "R10";
    if ({cfgHi, cfgLo} != appliedCfg || timingEn != appliedEn) return "R9";
    if (nib[3]) return "R7";
    if (nib[1:0] == 2'd0) return "R2";
    if (nib[2] && !appliedEn) return "R8";
    if (nib[2]) return "R4";
    return "R5";
  endfunction

  function automatic int firstBad(logic [7:0] a, logic [7:0] b);
    for (int i = 0; i < 8; i++) if (a[i] !== b[i]) return i;
    return 0;
  endfunction

  initial begin
    rstN = 1'b0; frameSync = 1'b0; timingEn = 1'b0;
    cfgLo = '0; cfgHi = '0; rxLane = '0; txLane = '0;
    void'($urandom(32'd20240611));
    appliedCfg = '0; appliedEn = 1'b0; syncSeen = 1'b0; lastSync = 0;
    expValid = '0; expFirst = '0; expOut = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "bitOut", bitOut, 8'h00);
    chk("R1", "bitValid", bitValid, 8'h00);
    chk("R1", "frameStart", frameStart, 8'h00);
    rstN = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      int pos, frameNo;
      @(negedge clk);
      chk(tagFor(firstBad(bitValid, expValid)), "bitValid", bitValid, expValid);
      chk("R6", "frameStart", frameStart, expFirst);
      chk(tagFor(firstBad(bitOut, expOut)), "bitOut", bitOut, expOut);

      rxLane = 8'($urandom);
      txLane = 8'($urandom);
      frameSync = (k >= T0) && (((k - T0) % TOT) == 0);
      frameNo = (k >= T0) ? (k - T0) / TOT : -1;
      pos = (k >= T0) ? (k - T0) % TOT : 0;
      if (frameNo >= 0 && pos == TOT - 5) begin
        case (frameNo + 1)
          1: begin cfgLo = 16'h4444; cfgHi = 16'h4040; timingEn = 1'b1; end // R2 dir ignored
          2: begin cfgLo = 16'h1765; cfgHi = 16'hFC32; timingEn = 1'b1; end // R4 R5 R7
          3: begin cfgLo = 16'h1765; cfgHi = 16'hFC32; timingEn = 1'b0; end // R8
          4: begin cfgLo = 16'h8D9E; cfgHi = 16'hBFAC; timingEn = 1'b1; end // R7
          default: ;
        endcase
      end
      // R9: mid-frame random changes must wait for the next sync
      if (frameNo >= 4 && pos == 40) begin
        cfgLo = 16'($urandom); cfgHi = 16'($urandom); timingEn = 1'($urandom);
      end

      for (int i = 0; i < 8; i++) begin
        logic [3:0] nib;
        int lt;
        nib = appliedCfg[i*4 +: 4];
        if (syncSeen) begin
          lt = (((k - lastSync) - offB(nib, appliedEn)) % TOT + TOT) % TOT;
          expValid[i] = ((lt % 4) == 3);
          expFirst[i] = expValid[i] && (lt < 4);
          if (expValid[i]) expOut[i] = nib[3] ? txLane[i] : rxLane[i];
        end else begin
          expValid[i] = 1'b0;
          expFirst[i] = 1'b0;
        end
      end
      if (frameSync) begin
        appliedCfg = {cfgHi, cfgLo};
        appliedEn  = timingEn;
        lastSync   = k;
        syncSeen   = 1'b1;
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule